// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector with Selectable Pump Polarity

This block compares a divided reference clock with a divided feedback clock and produces two pump-control pulses for a charge pump. Both inputs are brought into a fast sampling clock domain through synchronizer chains, and only their rising edges matter. The input whose edge arrives first raises its pump output. That output stays high until the other input's edge also arrives, so the pulse width in sampling cycles follows the phase error. Once both pump controls are high, a short programmable overlap clears them together. The forced overlap means both outputs always fire together for a minimum time, even at zero phase error, which removes the dead zone of the following charge pump.

A polarity input exchanges the two pump outputs. This lets the same detector drive an oscillator whose frequency falls with tuning voltage. While one side is pending, further edges on that input are ignored. This gives a tri-state behaviour with a ±2π range, so a frequency offset always pushes in one consistent direction. A lock flag rises after a run of consecutive comparisons in which neither pump output went high alone.

Top module: `pfd_polarity`

## Requirements
- R1: A rising edge on `refIn` or `fbIn` raises the pump output it drives on the third rising clock edge after the input changes (two synchronizer flops plus the pump state flop).
- R2: With `invertPol`=0 and the feedback edge lagging the reference edge by k sampling cycles, `pumpUp` is high for k+D+1 cycles and `pumpDown` for D+1 cycles. D is the value on `rstDelay` (0 to 3), so the programmed overlap is 1 to 4 cycles.
- R3: With `invertPol`=0 and the feedback edge leading by k cycles, `pumpDown` is high for k+D+1 cycles and `pumpUp` for D+1 cycles.
- R4: With `invertPol`=1, the widths of `pumpUp` and `pumpDown` are exchanged relative to R2 and R3.
- R5: When both edges arrive in the same sampling cycle, `pumpUp` and `pumpDown` rise together, are high together for exactly D+1 cycles, and fall together.
- R6: A further rising edge on an input whose pump side is already pending is ignored. Two reference edges before one feedback edge give one continuous `pumpUp` pulse (one rise) lasting from the first reference edge to the feedback edge plus D+1 cycles.
- R7: `locked` goes high at the end of the LOCK_CYCLES-th consecutive comparison (default 16) in which no output was high alone. It is low after one fewer such comparisons.
- R8: A comparison in which one output was high alone for at least one cycle drops `locked` to 0 and restarts the count.
- R9: While `rst_n` is low, `pumpUp`, `pumpDown` and `locked` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock (at least 8x the comparison rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| refIn | input | 1 | Divided reference clock, asynchronous |
| fbIn | input | 1 | Divided feedback clock, asynchronous |
| invertPol | input | 1 | 1 swaps the roles of the two pump outputs |
| rstDelay | input | 2 | Overlap length minus one, in sampling cycles |
| pumpUp | output | 1 | Pump-up control |
| pumpDown | output | 1 | Pump-down control |
| locked | output | 1 | Consecutive tight comparisons reached LOCK_CYCLES |

## Verification
The detector is driven with reference-leading, feedback-leading and coincident edge pairs, across random leads, every overlap setting and both polarities. The leading and lagging cases show whether the pulse width follows the phase error in both directions. The coincident case isolates the forced overlap alone, and the polarity sweep catches outputs that are swapped or not swapped. A pattern with two reference edges before one feedback edge separates a true tri-state detector from one that re-triggers. Runs of aligned comparisons, followed by one offset comparison, place the exact comparison at which the lock flag rises and show that it falls afterwards.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // strobes from the pump control to the counting datapath
  typedef struct packed {
    logic overlap;  // both pump sides pending
    logic lone;     // exactly one side pending
    logic clear;    // both sides clear at the next edge
  } pfdStrobe_t;
endpackage

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_W       = 2,
  parameter int LOCK_CYCLES = 16,
  parameter int LONE_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refIn,
  input  logic             fbIn,
  input  logic [DLY_W-1:0] rstDelay,
  input  pfdStrobe_t       strobe,
  output logic             refRise,
  output logic             fbRise,
  output logic             ovDone,
  output logic             locked
);
  localparam int LOCK_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [LOCK_W-1:0] LOCK_MAX = LOCK_W'(LOCK_CYCLES);
  localparam logic [LONE_W-1:0] LONE_MAX = '1;

  logic [SYNC_STAGES-1:0] refPipe, fbPipe;
  logic refPrev, fbPrev;
  logic [DLY_W-1:0]  ovCnt;
  logic [LONE_W-1:0] loneCnt;
  logic [LOCK_W-1:0] lockCnt;

  // synchronizer chains, one per input
  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          refPipe <= '0;
          fbPipe  <= '0;
        end else begin
          refPipe <= {refPipe[SYNC_STAGES-2:0], refIn};
          fbPipe  <= {fbPipe[SYNC_STAGES-2:0], fbIn};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          refPipe <= '0;
          fbPipe  <= '0;
        end else begin
          refPipe <= refIn;
          fbPipe  <= fbIn;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refPrev <= 1'b0;
      fbPrev  <= 1'b0;
    end else begin
      refPrev <= refPipe[SYNC_STAGES-1];
      fbPrev  <= fbPipe[SYNC_STAGES-1];
    end
  end

  assign refRise = refPipe[SYNC_STAGES-1] & ~refPrev;
  assign fbRise  = fbPipe[SYNC_STAGES-1] & ~fbPrev;

  // overlap length counter
  always_ff @(posedge clk) begin
    if (!rst_n || !strobe.overlap || strobe.clear) ovCnt <= '0;
    else                                           ovCnt <= ovCnt + 1'b1;
  end
  assign ovDone = (ovCnt == rstDelay);

  // cycles with a single pending side in the current comparison
  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clear)                 loneCnt <= '0;
    else if (strobe.lone && loneCnt != LONE_MAX) loneCnt <= loneCnt + 1'b1;
  end

  // consecutive tight comparisons
  always_ff @(posedge clk) begin
    if (!rst_n) lockCnt <= '0;
    else if (strobe.clear) begin
      if (loneCnt != '0)          lockCnt <= '0;
      else if (lockCnt != LOCK_MAX) lockCnt <= lockCnt + 1'b1;
    end
  end
  assign locked = (lockCnt == LOCK_MAX);

  a_r1_ref_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    refRise |=> !refRise);
  a_r8_miss_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.clear && loneCnt != '0) |=> !locked);
endmodule

// File: rtl/pfd_ctrl.sv
module pfd_ctrl
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refRise,
  input  logic       fbRise,
  input  logic       ovDone,
  output logic       rawUp,
  output logic       rawDn,
  output pfdStrobe_t strobe
);
  logic bothSet, clearNow;

  assign bothSet  = rawUp & rawDn;
  assign clearNow = bothSet & ovDone;

  // a new edge in the clearing cycle still starts the next comparison
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rawUp <= 1'b0;
      rawDn <= 1'b0;
    end else if (clearNow) begin
      rawUp <= refRise;
      rawDn <= fbRise;
    end else begin
      rawUp <= rawUp | refRise;
      rawDn <= rawDn | fbRise;
    end
  end

  always_comb begin
    strobe.overlap = bothSet;
    strobe.lone    = rawUp ^ rawDn;
    strobe.clear   = clearNow;
  end

  a_r5_clear_together: assert property (@(posedge clk) disable iff (!rst_n)
    (bothSet && ovDone && !refRise && !fbRise) |=> (!rawUp && !rawDn));
  a_r6_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!rawUp && !refRise) |=> !rawUp);
  a_r6_pending_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (rawUp && !rawDn && !fbRise) |=> rawUp);
endmodule

// File: rtl/pfd_polarity.sv
module pfd_polarity
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_W       = 2,
  parameter int LOCK_CYCLES = 16,
  parameter int LONE_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refIn,
  input  logic             fbIn,
  input  logic             invertPol,
  input  logic [DLY_W-1:0] rstDelay,
  output logic             pumpUp,
  output logic             pumpDown,
  output logic             locked
);
  pfdStrobe_t strobe;
  logic refRise, fbRise, ovDone, rawUp, rawDn;

  pfd_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .DLY_W(DLY_W),
    .LOCK_CYCLES(LOCK_CYCLES), .LONE_W(LONE_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .refIn(refIn), .fbIn(fbIn),
    .rstDelay(rstDelay), .strobe(strobe), .refRise(refRise),
    .fbRise(fbRise), .ovDone(ovDone), .locked(locked)
  );

  pfd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .refRise(refRise), .fbRise(fbRise),
    .ovDone(ovDone), .rawUp(rawUp), .rawDn(rawDn), .strobe(strobe)
  );

  assign pumpUp   = invertPol ? rawDn : rawUp;
  assign pumpDown = invertPol ? rawUp : rawDn;

  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!pumpUp && !pumpDown && !locked));
endmodule

// File: tb/pfd_polarity_test.sv
module pfd_polarity_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refIn = 1'b0, fbIn = 1'b0, invertPol = 1'b0;
  logic [1:0] rstDelay = 2'd0;
  logic pumpUp, pumpDown, locked;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pfd_polarity uut (
    .clk(clk), .rst_n(rst_n), .refIn(refIn), .fbIn(fbIn),
    .invertPol(invertPol), .rstDelay(rstDelay),
    .pumpUp(pumpUp), .pumpDown(pumpDown), .locked(locked)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // width of the lagging-side pulse model: lead>0 means feedback lags
  function automatic int expUp(int lead, bit pol, int d);
    int ref_w = (lead > 0 ? lead : 0) + d + 1;
    int fb_w  = (lead < 0 ? -lead : 0) + d + 1;
    return pol ? fb_w : ref_w;
  endfunction
  function automatic int expDn(int lead, bit pol, int d);
    return expUp(lead, !pol, d);
  endfunction

  // drives 4-cycle pulses; refB < 0 means no second reference pulse
  task automatic runWindow(input int refA, input int refB, input int fbA,
                           input int len, output int upW, output int dnW,
                           output int bothW, output int upRises,
                           output int firstUp, output int firstDn);
    logic pu = 1'b0;
    upW = 0; dnW = 0; bothW = 0; upRises = 0; firstUp = -1; firstDn = -1;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      if (pumpUp) begin
        upW++;
        if (firstUp < 0) firstUp = c;
        if (!pu) upRises++;
      end
      if (pumpDown) begin
        dnW++;
        if (firstDn < 0) firstDn = c;
      end
      if (pumpUp && pumpDown) bothW++;
      pu = pumpUp;
      refIn = ((c >= refA && c < refA + 4) || (refB >= 0 && c >= refB && c < refB + 4));
      fbIn  = (c >= fbA && c < fbA + 4);
    end
  endtask

  task automatic compare(int lead, bit pol, int d, string req);
    int uw, dw, bw, ur, fu, fd, ra, fa;
    invertPol = pol;
    rstDelay  = 2'(d);
    ra = 10 + (lead < 0 ? -lead : 0);
    fa = 10 + (lead > 0 ? lead : 0);
    runWindow(ra, -1, fa, 40, uw, dw, bw, ur, fu, fd);
    check({req, " up width"}, uw, expUp(lead, pol, d));
    check({req, " down width"}, dw, expDn(lead, pol, d));
    check({req, " overlap"}, bw, d + 1);
  endtask

  initial begin
    int uw, dw, bw, ur, fu, fd, seedv;
    seedv = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check("R9 pumpUp in reset", int'(pumpUp), 0);
    check("R9 pumpDown in reset", int'(pumpDown), 0);
    check("R9 locked in reset", int'(locked), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: latency of the leading edge
    invertPol = 1'b0; rstDelay = 2'd1;
    runWindow(10, -1, 14, 40, uw, dw, bw, ur, fu, fd);
    check("R1 first pumpUp cycle", fu, 13);
    check("R1 first pumpDown cycle", fd, 17);
    check("R2 up width lead 4", uw, 4 + 2);

    compare(3, 1'b0, 0, "R2");
    compare(-5, 1'b0, 2, "R3");
    compare(3, 1'b1, 3, "R4");
    compare(-2, 1'b1, 1, "R4");
    for (int d = 0; d < 4; d++) compare(0, 1'b0, d, "R5");
    compare(0, 1'b1, 3, "R5");

    // R6: two reference edges before one feedback edge
    invertPol = 1'b0; rstDelay = 2'd2;
    runWindow(5, 15, 25, 45, uw, dw, bw, ur, fu, fd);
    check("R6 up rises", ur, 1);
    check("R6 up width", uw, 20 + 3);
    check("R6 down width", dw, 3);

    // random leads, polarities and overlaps
    for (int i = 0; i < 30; i++) begin
      int lead = int'($urandom_range(12)) - 6;
      compare(lead, 1'($urandom_range(1)), int'($urandom_range(3)),
              lead > 0 ? "R2/R4 random" : (lead < 0 ? "R3/R4 random" : "R5 random"));
    end

    // R7/R8: lock sequencing
    compare(3, 1'b0, 1, "R8 prep");
    check("R8 unlocked after offset", int'(locked), 0);
    for (int i = 0; i < 15; i++) compare(0, 1'b0, 1, "R7 aligned");
    check("R7 not locked after 15", int'(locked), 0);
    compare(0, 1'b0, 1, "R7 aligned");
    check("R7 locked after 16", int'(locked), 1);
    compare(0, 1'b1, 2, "R7 aligned");
    check("R7 stays locked", int'(locked), 1);
    compare(-2, 1'b0, 1, "R8 offset");
    check("R8 lock dropped", int'(locked), 0);

    // R9: reset in the middle of a pending pulse
    refIn = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 pumpUp after reset", int'(pumpUp), 0);
    check("R9 pumpDown after reset", int'(pumpDown), 0);
    refIn = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule